// File: doc/BRIEF.md
# Hierarchical Leading-Zero Counter

The block counts how many zero bits precede the first set bit of a data word, scanning from the most significant bit downward, and reports that count together with a flag saying whether any bit was set at all and a flag saying the word was entirely zero. The whole count is formed in one pass of combinational logic between two register stages, with no iteration over clock cycles and no faster internal clock.

The word is split into 8-bit groups. Each group has its own small priority encoder that yields a leading-zero index inside the group and a flag telling whether the group holds a one. A second encoder of the same kind runs over those group flags. Its index is the number of all-zero groups above the first non-zero one and forms the upper count bits. The index of the group it picks forms the lower count bits. A strobe captures a word into the input register. The result registers load on the following clock, so a result appears one clock after capture, and words may be strobed on every cycle.

Top module: `lzc_unit`

## Requirements
- R1: While reset (synchronous, active high) is sampled high, the registered outputs become count 0, all-zero flag 0 and found flag 0 on the next clock edge.
- R2: A word presented with the strobe high at clock edge k produces its result on the outputs just after edge k+1. Strobes on consecutive edges give one result per cycle, in order.
- R3: For a non-zero word, the count equals the number of zero bits above the highest set bit, where bit 31 is scanned first. A word with bit 31 set counts 0, and a word whose only set bit is bit 0 counts 31.
- R4: For words whose upper 24 bits are zero, every one of the 256 low-byte values yields 24 plus the leading-zero count of that byte. The all-zero byte is covered by R5.
- R5: An all-zero word yields a count of 32, all-zero flag 1 and found flag 0.
- R6: For any captured word, the found flag is 1 exactly when the word is non-zero, and the all-zero flag is its complement.
- R7: Bits below the highest set bit have no effect on the count.
- R8: While the strobe is low, changes on the data input have no effect, and the outputs hold the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stb_i | input | 1 | Capture strobe for data_i |
| data_i | input | 32 | Word to be scanned |
| count_o | output | 6 | Leading-zero count, 0 to 32 |
| zero_o | output | 1 | Captured word was all zero |
| found_o | output | 1 | Captured word held at least one set bit |

## Verification
Uniform random 32-bit words nearly always have a set bit in the top group, so the upper-level selection of a lower group is rarely reached that way. The stimulus shifts each random word right by a random amount of 0 to 32 places and also runs walking-one patterns with random bits below the one. This places the first set bit in every group and at both edges of each group. A full sweep of the lowest byte with the upper 24 bits zero drives the deepest selection through all 256 leaf patterns. Back-to-back strobes and changing data with the strobe low exercise the capture timing.

// File: rtl/lzc_pkg.sv
package lzc_pkg;

    localparam int LZ_WORD_W = 32;
    localparam int LZ_LEAF_W = 8;

    // Width able to hold every count from 0 up to the full word width.
    function automatic int lz_cnt_w(input int word_w);
        return $clog2(word_w + 1);
    endfunction

    // Registered result of one scan.
    typedef struct packed {
        logic found;
        logic zero;
    } lz_flags_t;

endpackage

// File: rtl/lzc_prio.sv
// Priority encoder: index of the highest set bit, counted from the top,
// plus a flag that is high only when some bit is set.
module lzc_prio #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] lead
);

    always_comb begin
        found = 1'b0;
        lead  = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                lead  = IW'(W - 1 - i);
            end
        end
    end

    // R3: the reported position holds a one and nothing above it is set
    always_comb begin
        if (found) begin
            a_r3_first_one: assert (bits[W - 1 - int'(lead)]);
            if (lead != '0)
                a_r3_none_above: assert ((bits >> (W - int'(lead))) == '0);
        end
    end

endmodule

// File: rtl/lzc_tree.sv
// Two-level tree: leaf encoders per group, one encoder over the group flags.
module lzc_tree #(
    parameter int WORD_W = 32,
    parameter int LEAF_W = 8,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  count,
    output logic              found
);

    localparam int N_GRP = WORD_W / LEAF_W;
    localparam int LIW   = $clog2(LEAF_W);
    localparam int GIW   = $clog2(N_GRP);

    logic [N_GRP-1:0] grp_found;
    logic [LIW-1:0]   grp_lead [N_GRP];
    logic [GIW-1:0]   top_lead;
    logic [GIW-1:0]   win_grp;
    logic [LIW-1:0]   win_lead;

    for (genvar g = 0; g < N_GRP; g++) begin : g_leaf
        lzc_prio #(.W(LEAF_W), .IW(LIW)) u_leaf (
            .bits  (word[g*LEAF_W +: LEAF_W]),
            .found (grp_found[g]),
            .lead  (grp_lead[g])
        );
    end

    lzc_prio #(.W(N_GRP), .IW(GIW)) u_upper (
        .bits  (grp_found),
        .found (found),
        .lead  (top_lead)
    );

    // Group index counts from the bottom; top_lead counts zero groups from the top.
    assign win_grp  = GIW'(N_GRP - 1) - top_lead;
    assign win_lead = grp_lead[win_grp];

    always_comb begin
        if (found)
            count = CNT_W'({top_lead, win_lead});
        else
            count = CNT_W'(WORD_W);
    end

endmodule

// File: rtl/lzc_unit.sv
module lzc_unit
    import lzc_pkg::*;
#(
    parameter int WORD_W = LZ_WORD_W,
    parameter int LEAF_W = LZ_LEAF_W,
    localparam int CNT_W = lz_cnt_w(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              zero_o,
    output logic              found_o
);

    logic [WORD_W-1:0] word_q;
    logic              pend_q;
    logic [CNT_W-1:0]  tree_cnt;
    logic              tree_found;
    logic [CNT_W-1:0]  count_q;
    lz_flags_t         flags_q;

    lzc_tree #(.WORD_W(WORD_W), .LEAF_W(LEAF_W), .CNT_W(CNT_W)) u_tree (
        .word  (word_q),
        .count (tree_cnt),
        .found (tree_found)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            pend_q  <= 1'b0;
            count_q <= '0;
            flags_q <= '0;
        end else begin
            pend_q <= stb_i;
            if (stb_i)
                word_q <= data_i;
            if (pend_q) begin
                count_q       <= tree_cnt;
                flags_q.found <= tree_found;
                flags_q.zero  <= ~tree_found;
            end
        end
    end

    assign count_o = count_q;
    assign zero_o  = flags_q.zero;
    assign found_o = flags_q.found;

    // R1: reset clears the result registers
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !zero_o && !found_o));

    // R5: all-zero result carries the full width and no found flag
    a_r5_zero_full: assert property (@(posedge clk) disable iff (rst)
        zero_o |-> (count_o == CNT_W'(WORD_W) && !found_o));

    // R6: the two flags never both hold
    a_r6_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(zero_o && found_o));

    // R3: a found word never counts past the last bit
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        found_o |-> (count_o < CNT_W'(WORD_W)));

    // R2: a pending capture always lands a result
    a_r2_result_lands: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> (zero_o || found_o));

    // R8: without a pending capture the outputs hold
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !pend_q |=> ($stable(count_o) && $stable(zero_o) && $stable(found_o)));

endmodule

// File: tb/lzc_unit_test.sv
`timescale 1ns/1ps
module lzc_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [5:0]  count_o;
    logic        zero_o;
    logic        found_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    lzc_unit uut (
        .clk(clk), .rst(rst), .stb_i(stb_i), .data_i(data_i),
        .count_o(count_o), .zero_o(zero_o), .found_o(found_o)
    );

    always #4 clk = ~clk;

    function automatic int ref_lz(input logic [31:0] w);
        for (int b = 31; b >= 0; b--)
            if (w[b]) return 31 - b;
        return 32;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_word(input string tag, input logic [31:0] w);
        chk({tag, " count"}, int'(count_o), ref_lz(w));
        chk({tag, " found (R6)"}, int'(found_o), int'(w != 0));
        chk({tag, " zero (R6)"}, int'(zero_o), int'(w == 0));
    endtask

    // One word: strobe for one edge, check one edge after capture.
    task automatic send(input string tag, input logic [31:0] w);
        @(negedge clk); data_i = w; stb_i = 1'b1;
        @(negedge clk); stb_i = 1'b0;
        @(negedge clk); chk_word(tag, w);
    endtask

    initial begin
        logic [31:0] w, a, b, last;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state after reset
        chk("R1 count", int'(count_o), 0);
        chk("R1 zero", int'(zero_o), 0);
        chk("R1 found", int'(found_o), 0);

        // R3 ends of the word, R5 all zero
        send("R3 top bit", 32'h8000_0000);
        send("R3 bottom bit", 32'h0000_0001);
        send("R5 all zero", 32'h0000_0000);
        chk("R5 count", int'(count_o), 32);
        send("R3 all ones", 32'hFFFF_FFFF);

        // R4: every low-byte value with upper bits zero
        for (int v = 1; v < 256; v++)
            send("R4 low byte", 32'(v));

        // R3/R7: walking one with random bits below it
        for (int p = 0; p < 32; p++) begin
            w = (32'h1 << p) | ($urandom & ((32'h1 << p) - 32'h1));
            send("R7 walk", w);
        end

        // R3: random words spread over all leading-zero counts
        for (int n = 0; n < 400; n++) begin
            w = $urandom >> ($urandom % 33);
            send("R3 random", w);
        end

        // R2: back-to-back strobes give results on consecutive cycles
        for (int n = 0; n < 20; n++) begin
            a = $urandom >> ($urandom % 33);
            b = $urandom >> ($urandom % 33);
            @(negedge clk); data_i = a; stb_i = 1'b1;
            @(negedge clk); data_i = b;
            @(negedge clk); stb_i = 1'b0; chk_word("R2 first", a);
            @(negedge clk); chk_word("R2 second", b);
        end

        // R8: data changes without strobe leave the result alone
        last = 32'h0004_0000;
        send("R8 base", last);
        for (int n = 0; n < 10; n++) begin
            @(negedge clk); data_i = $urandom;
        end
        @(negedge clk); @(negedge clk);
        chk_word("R8 held", last);

        // R1: reset during operation clears a held result
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 mid count", int'(count_o), 0);
        chk("R1 mid found", int'(found_o), 0);
        chk("R1 mid zero", int'(zero_o), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule